// File: doc/BRIEF.md
# Page Write Buffer and Commit Timer

This block sits behind the serial command decoder of a small non-volatile memory. When a write command starts, the decoder hands over a start address. It then passes each received data byte with a one-cycle strobe, and finally signals the end of the transaction when chip select rises. The block gathers the bytes into a one-page staging buffer. The page is 32 bytes and is selected by the upper address bits. Each byte is placed at an in-page offset that advances with every byte and wraps inside the page, so a long burst overwrites its own earlier bytes.

At the end of the transaction the decoder also presents a write-allowed qualifier, which carries the outcome of its protection checks. If that qualifier is high and at least one byte arrived, the block starts a self-timed write cycle. During that cycle `busy` is held high for a fixed number of clock cycles. In the first 32 cycles the block walks the page offsets in ascending order and issues one array write for each offset that actually received a byte. When the cycle ends, the block gives a one-cycle pulse that the decoder uses to clear its write-enable latch. A refused or empty command is dropped without any trace.

Top module: `page_write_engine`

## Requirements
- R1: After reset, `busy`, `arr_we` and `wen_clr` are low.
- R2: Every array write of a command uses the start address bits [9:5] as its upper address bits. The first byte goes to offset start[4:0] and each later byte goes to the next offset.
- R3: After offset 31 the next byte goes to offset 0 of the same page.
- R4: When more than 32 bytes are sent, each offset holds the last byte received for it, so the page ends up with the final 32 bytes.
- R5: Only offsets that received a byte are written, each exactly once. The writes come in ascending offset order: in busy cycle k (counting from 0), offset k is written if it was received.
- R6: No array write and no busy period happen before the end-of-transaction strobe.
- R7: `busy` rises on the clock edge that samples an accepted end-of-transaction and stays high for exactly WRITE_CYCLES cycles (WRITE_CYCLES >= 32).
- R8: `wen_clr` is a single-cycle pulse in the first cycle after `busy` falls, and appears only after a write cycle.
- R9: If `wr_allow` is low at the end of the transaction, there is no busy period, no array write and no `wen_clr`. The buffered bytes are discarded, so the next command writes only its own bytes.
- R10: A command that ends without any data byte starts no busy period.
- R11: While `busy` is high, start, byte and end-of-transaction strobes are ignored. They do not change the bytes being written and do not start a second write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_vld | input | 1 | Start of a write command; latches `start_addr` |
| start_addr | input | 10 | First byte address of the command |
| byte_vld | input | 1 | One received data byte is present |
| byte_data | input | 8 | Received data byte |
| txn_end | input | 1 | End of transaction (chip select risen) |
| wr_allow | input | 1 | Protection verdict, sampled with `txn_end` |
| arr_we | output | 1 | Array byte write strobe |
| arr_addr | output | 10 | Array byte address |
| arr_data | output | 8 | Array byte data |
| busy | output | 1 | Write cycle in progress |
| wen_clr | output | 1 | Pulse that clears the write-enable latch |

## Verification
On every cycle, the assertions check the following. Array writes occur only while busy. Within one write cycle, writes stay in one page and climb in offset. Busy cannot end early. The enable-clear pulse follows the fall of busy. A refused end of transaction never raises busy. Only the bench scenarios can show which bytes end up at which offsets: wrapping, overwrite by long bursts, and partial pages that leave other offsets untouched. The same holds for discarding a refused buffer and for ignoring strobes that arrive during a write cycle, since these depend on the whole command history and not on a single cycle.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [0:0] {
        COL_IDLE = 1'b0,
        COL_FILL = 1'b1
    } col_state_e;

    typedef struct packed {
        logic  we;
        byte_t data;
    } arr_beat_t;

    function automatic bit is_pow2(input int unsigned n);
        return (n != 0) && ((n & (n - 1)) == 0);
    endfunction

endpackage

// File: rtl/pwb_collect.sv
module pwb_collect
    import pwb_pkg::*;
#(
    parameter int unsigned ADDR_W     = 10,
    parameter int unsigned PAGE_BYTES = 32,
    localparam int unsigned OFF_W     = $clog2(PAGE_BYTES),
    localparam int unsigned PG_W      = ADDR_W - OFF_W
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        busy,
    input  logic                        start_vld,
    input  logic [ADDR_W-1:0]           start_addr,
    input  logic                        byte_vld,
    input  byte_t                       byte_data,
    input  logic                        txn_end,
    input  logic                        wr_allow,
    output logic                        commit_go,
    output logic [PG_W-1:0]             page_q,
    output logic [PAGE_BYTES-1:0]       mask_q,
    output byte_t [PAGE_BYTES-1:0]      pg_data_q
);

    col_state_e                state_q;
    logic [OFF_W-1:0]          off_q;
    logic [OFF_W-1:0]          off_nxt;
    logic [PAGE_BYTES-1:0]     mask_nxt;
    byte_t [PAGE_BYTES-1:0]    pg_data_nxt;
    logic                      start_ok;
    logic                      filling;

    assign start_ok = start_vld && !busy;
    assign filling  = (state_q == COL_FILL) && !busy;

    always_comb begin
        mask_nxt    = mask_q;
        pg_data_nxt = pg_data_q;
        off_nxt     = off_q;
        if (filling && byte_vld) begin
            pg_data_nxt[off_q] = byte_data;
            mask_nxt[off_q]    = 1'b1;
            off_nxt            = off_q + 1'b1;
        end
    end

    assign commit_go = filling && !start_ok && txn_end && wr_allow && (|mask_nxt);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= COL_IDLE;
            off_q     <= '0;
            page_q    <= '0;
            mask_q    <= '0;
            pg_data_q <= '0;
        end else if (start_ok) begin
            state_q <= COL_FILL;
            page_q  <= start_addr[ADDR_W-1:OFF_W];
            off_q   <= start_addr[OFF_W-1:0];
            mask_q  <= '0;
        end else if (filling) begin
            pg_data_q <= pg_data_nxt;
            off_q     <= off_nxt;
            if (txn_end) begin
                state_q <= COL_IDLE;
                mask_q  <= commit_go ? mask_nxt : '0;
            end else begin
                mask_q  <= mask_nxt;
            end
        end
    end

    initial begin
        if (!is_pow2(PAGE_BYTES)) $error("PAGE_BYTES must be a power of two");
    end

    AST_MASK_KEEPS_BITS: assert property (@(posedge clk) disable iff (rst)
        (filling && !start_ok && !txn_end) |=> ($countones(mask_q) >= $countones($past(mask_q))))
        else $error("mask lost a received byte"); // R4

    AST_FILL_HOLDS_PAGE: assert property (@(posedge clk) disable iff (rst)
        (filling && !start_ok) |=> (page_q == $past(page_q)))
        else $error("page changed inside a command"); // R2

endmodule

// File: rtl/pwb_timer.sv
module pwb_timer #(
    parameter int unsigned WRITE_CYCLES = 1250000,
    localparam int unsigned CNT_W       = $clog2(WRITE_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    output logic             busy,
    output logic [CNT_W-1:0] cnt,
    output logic             wen_clr
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(WRITE_CYCLES - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            cnt     <= '0;
            wen_clr <= 1'b0;
        end else begin
            wen_clr <= 1'b0;
            if (!busy) begin
                if (go) begin
                    busy <= 1'b1;
                    cnt  <= '0;
                end
            end else if (cnt == LAST) begin
                busy    <= 1'b0;
                cnt     <= '0;
                wen_clr <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    AST_BUSY_NOT_EARLY: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt != LAST) |=> busy)
        else $error("busy ended early"); // R7

    AST_CLR_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
        wen_clr |-> (!busy && $past(busy)))
        else $error("enable-clear pulse without a finished cycle"); // R8

    AST_CLR_SINGLE: assert property (@(posedge clk) disable iff (rst)
        wen_clr |=> !wen_clr)
        else $error("enable-clear pulse longer than one cycle"); // R8

endmodule

// File: rtl/pwb_drain.sv
module pwb_drain
    import pwb_pkg::*;
#(
    parameter int unsigned ADDR_W     = 10,
    parameter int unsigned PAGE_BYTES = 32,
    parameter int unsigned CNT_W      = 21,
    localparam int unsigned OFF_W     = $clog2(PAGE_BYTES),
    localparam int unsigned PG_W      = ADDR_W - OFF_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   busy,
    input  logic [CNT_W-1:0]       cnt,
    input  logic [PG_W-1:0]        page_q,
    input  logic [PAGE_BYTES-1:0]  mask_q,
    input  byte_t [PAGE_BYTES-1:0] pg_data_q,
    output logic                   arr_we,
    output logic [ADDR_W-1:0]      arr_addr,
    output byte_t                  arr_data
);

    logic [OFF_W-1:0] slot;
    logic             in_scan;
    arr_beat_t        beat;

    assign slot    = cnt[OFF_W-1:0];
    assign in_scan = busy && (cnt < CNT_W'(PAGE_BYTES));

    always_comb begin
        beat.we   = in_scan && mask_q[slot];
        beat.data = pg_data_q[slot];
    end

    assign arr_we   = beat.we;
    assign arr_data = beat.data;
    assign arr_addr = {page_q, slot};

    AST_WE_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
        arr_we |-> busy)
        else $error("array write outside a write cycle"); // R6

    AST_WE_ASCENDING: assert property (@(posedge clk) disable iff (rst)
        arr_we |=> (!arr_we || arr_addr[OFF_W-1:0] > $past(arr_addr[OFF_W-1:0])))
        else $error("array writes out of offset order"); // R5

    AST_WE_SAME_PAGE: assert property (@(posedge clk) disable iff (rst)
        arr_we |=> (!arr_we || arr_addr[ADDR_W-1:OFF_W] == $past(arr_addr[ADDR_W-1:OFF_W])))
        else $error("array writes crossed a page"); // R2

endmodule

// File: rtl/page_write_engine.sv
module page_write_engine
    import pwb_pkg::*;
#(
    parameter int unsigned ADDR_W       = 10,
    parameter int unsigned PAGE_BYTES   = 32,
    parameter int unsigned WRITE_CYCLES = 1250000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_vld,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              byte_vld,
    input  logic [7:0]        byte_data,
    input  logic              txn_end,
    input  logic              wr_allow,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [7:0]        arr_data,
    output logic              busy,
    output logic              wen_clr
);

    localparam int unsigned OFF_W = $clog2(PAGE_BYTES);
    localparam int unsigned PG_W  = ADDR_W - OFF_W;
    localparam int unsigned CNT_W = $clog2(WRITE_CYCLES + 1);

    logic                   commit_go;
    logic [PG_W-1:0]        page_q;
    logic [PAGE_BYTES-1:0]  mask_q;
    byte_t [PAGE_BYTES-1:0] pg_data_q;
    logic [CNT_W-1:0]       cnt;

    initial begin
        if (WRITE_CYCLES < PAGE_BYTES) $error("WRITE_CYCLES must cover a full page scan");
    end

    pwb_collect #(
        .ADDR_W     (ADDR_W),
        .PAGE_BYTES (PAGE_BYTES)
    ) u_collect (
        .clk        (clk),
        .rst        (rst),
        .busy       (busy),
        .start_vld  (start_vld),
        .start_addr (start_addr),
        .byte_vld   (byte_vld),
        .byte_data  (byte_data),
        .txn_end    (txn_end),
        .wr_allow   (wr_allow),
        .commit_go  (commit_go),
        .page_q     (page_q),
        .mask_q     (mask_q),
        .pg_data_q  (pg_data_q)
    );

    pwb_timer #(
        .WRITE_CYCLES (WRITE_CYCLES)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .go      (commit_go),
        .busy    (busy),
        .cnt     (cnt),
        .wen_clr (wen_clr)
    );

    pwb_drain #(
        .ADDR_W     (ADDR_W),
        .PAGE_BYTES (PAGE_BYTES),
        .CNT_W      (CNT_W)
    ) u_drain (
        .clk       (clk),
        .rst       (rst),
        .busy      (busy),
        .cnt       (cnt),
        .page_q    (page_q),
        .mask_q    (mask_q),
        .pg_data_q (pg_data_q),
        .arr_we    (arr_we),
        .arr_addr  (arr_addr),
        .arr_data  (arr_data)
    );

    AST_REFUSED_NO_BUSY: assert property (@(posedge clk) disable iff (rst)
        (txn_end && !wr_allow && !busy) |=> !busy)
        else $error("refused command started a write cycle"); // R9

    AST_IDLE_STAYS_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!busy && !txn_end) |=> !busy)
        else $error("busy rose without end of transaction"); // R6

endmodule

// File: tb/tb_page_write_engine.sv
module tb_page_write_engine;

    localparam int ADDR_W = 10;
    localparam int PAGE   = 32;
    localparam int WC     = 40;

    logic              clk = 1'b0;
    logic              rst;
    logic              start_vld;
    logic [ADDR_W-1:0] start_addr;
    logic              byte_vld;
    logic [7:0]        byte_data;
    logic              txn_end;
    logic              wr_allow;
    logic              arr_we;
    logic [ADDR_W-1:0] arr_addr;
    logic [7:0]        arr_data;
    logic              busy;
    logic              wen_clr;

    int n_checks = 0;
    int n_fail   = 0;

    logic [7:0] got_data [PAGE];
    logic       got_hit  [PAGE];
    int         we_cnt, busy_cnt, clr_cnt, page_err, dup_err;
    logic [4:0] exp_page;

    always #2 clk = ~clk;

    page_write_engine #(
        .ADDR_W       (ADDR_W),
        .PAGE_BYTES   (PAGE),
        .WRITE_CYCLES (WC)
    ) dut (
        .clk        (clk),
        .rst        (rst),
        .start_vld  (start_vld),
        .start_addr (start_addr),
        .byte_vld   (byte_vld),
        .byte_data  (byte_data),
        .txn_end    (txn_end),
        .wr_allow   (wr_allow),
        .arr_we     (arr_we),
        .arr_addr   (arr_addr),
        .arr_data   (arr_data),
        .busy       (busy),
        .wen_clr    (wen_clr)
    );

    always @(negedge clk) begin
        if (arr_we) begin
            we_cnt++;
            if (got_hit[arr_addr[4:0]]) dup_err++;
            got_hit[arr_addr[4:0]]  = 1'b1;
            got_data[arr_addr[4:0]] = arr_data;
            if (arr_addr[9:5] != exp_page) page_err++;
        end
        if (busy)    busy_cnt++;
        if (wen_clr) clr_cnt++;
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clear_mon(input logic [9:0] addr);
        for (int i = 0; i < PAGE; i++) begin
            got_hit[i]  = 1'b0;
            got_data[i] = 8'h00;
        end
        we_cnt = 0; busy_cnt = 0; clr_cnt = 0; page_err = 0; dup_err = 0;
        exp_page = addr[9:5];
    endtask

    // Issue one command; returns one step after the edge that samples txn_end.
    task automatic issue(input string req, input logic [9:0] addr, input int n,
                         input logic [7:0] base, input logic allow);
        clear_mon(addr);
        @(posedge clk); #1;
        start_vld = 1'b1; start_addr = addr;
        @(posedge clk); #1;
        start_vld = 1'b0;
        for (int i = 0; i < n; i++) begin
            byte_vld = 1'b1; byte_data = base + 8'(i);
            @(posedge clk); #1;
        end
        byte_vld = 1'b0;
        chk(!busy && we_cnt == 0, "R6", "activity before end of transaction", we_cnt, 0);
        txn_end = 1'b1; wr_allow = allow;
        @(posedge clk); #1;
        txn_end = 1'b0; wr_allow = 1'b0;
        chk(busy == (allow && n > 0), "R7", "busy onset after end", int'(busy), int'(allow && n > 0));
    endtask

    task automatic settle();
        repeat (WC + 6) @(posedge clk);
        #1;
    endtask

    task automatic verify(input string req, input logic [9:0] addr, input int n,
                          input logic [7:0] base, input logic allow);
        logic [7:0] ed [PAGE];
        logic       eh [PAGE];
        int         mism = 0;
        bit         go = allow && n > 0;
        for (int i = 0; i < PAGE; i++) begin eh[i] = 1'b0; ed[i] = 8'h00; end
        if (go) begin
            for (int i = 0; i < n; i++) begin
                eh[(addr[4:0] + i) % PAGE] = 1'b1;
                ed[(addr[4:0] + i) % PAGE] = base + 8'(i);
            end
        end
        for (int i = 0; i < PAGE; i++)
            if (eh[i] != got_hit[i] || (eh[i] && ed[i] != got_data[i])) mism++;
        chk(mism == 0, req, "page content mismatches", mism, 0);
        chk(we_cnt == (go ? (n < PAGE ? n : PAGE) : 0), req, "array write count", we_cnt,
            go ? (n < PAGE ? n : PAGE) : 0);
        chk(dup_err == 0, "R5", "offset written twice", dup_err, 0);
        chk(page_err == 0, "R2", "writes outside selected page", page_err, 0);
        chk(busy_cnt == (go ? WC : 0), "R7", "busy cycles", busy_cnt, go ? WC : 0);
        chk(clr_cnt == (go ? 1 : 0), "R8", "enable-clear pulses", clr_cnt, go ? 1 : 0);
    endtask

    task automatic t_reset();
        rst = 1'b1; start_vld = 0; start_addr = '0; byte_vld = 0; byte_data = 0;
        txn_end = 0; wr_allow = 0;
        clear_mon(10'h000);
        repeat (3) @(posedge clk);
        #1;
        chk(!busy && !arr_we && !wen_clr, "R1", "outputs after reset",
            int'({busy, arr_we, wen_clr}), 0);
        rst = 1'b0;
        @(posedge clk); #1;
    endtask

    task automatic t_full_page();
        issue("R5", 10'h040, 32, 8'h10, 1'b1); settle();
        verify("R2", 10'h040, 32, 8'h10, 1'b1);
    endtask

    task automatic t_partial();
        issue("R5", 10'h1A3, 5, 8'hA0, 1'b1); settle();
        verify("R5", 10'h1A3, 5, 8'hA0, 1'b1);
    endtask

    task automatic t_wrap();
        issue("R3", 10'h33D, 6, 8'h55, 1'b1); settle();
        verify("R3", 10'h33D, 6, 8'h55, 1'b1);
    endtask

    task automatic t_overrun();
        issue("R4", 10'h2E4, 40, 8'h00, 1'b1); settle();
        verify("R4", 10'h2E4, 40, 8'h00, 1'b1);
    endtask

    task automatic t_refused();
        issue("R9", 10'h0C0, 20, 8'h70, 1'b0); settle();
        verify("R9", 10'h0C0, 20, 8'h70, 1'b0);
        issue("R9", 10'h0C7, 1, 8'hE1, 1'b1); settle();
        verify("R9", 10'h0C7, 1, 8'hE1, 1'b1);
    endtask

    task automatic t_empty();
        issue("R10", 10'h100, 0, 8'h00, 1'b1); settle();
        verify("R10", 10'h100, 0, 8'h00, 1'b1);
    endtask

    task automatic t_ignore_busy();
        issue("R11", 10'h205, 3, 8'h31, 1'b1);
        start_vld = 1'b1; start_addr = 10'h3E0;
        @(posedge clk); #1;
        start_vld = 1'b0;
        for (int i = 0; i < 4; i++) begin
            byte_vld = 1'b1; byte_data = 8'hF0 + 8'(i);
            @(posedge clk); #1;
        end
        byte_vld = 1'b0;
        txn_end = 1'b1; wr_allow = 1'b1;
        @(posedge clk); #1;
        txn_end = 1'b0; wr_allow = 1'b0;
        settle(); settle();
        verify("R11", 10'h205, 3, 8'h31, 1'b1);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_full_page();
                t_partial();
                t_wrap();
                t_overrun();
                t_refused();
                t_empty();
                t_ignore_busy();
            end
            begin
                repeat (150000) @(posedge clk);
                chk(1'b0, "WDOG", "watchdog expired", 0, 1);
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule